// File: doc/BRIEF.md
# Serial Output Power Sequencer

This block decides when the serial line driver of a video serializer may drive. It watches an active-high run request (the inverse of a power-down pin) and a flag that says the input buffer supply is present. While either is low, the driver is high impedance and its internal termination is disconnected. Once both are high, the termination is connected and held at zero differential while a wait counter counts pixel clocks. When the wait is over, the driver is enabled and a lock-done flag opens the framer's output shifter.

The block also decodes the 2-bit clock-range select. It reports the pixel clock window in kHz and the matching serial bit-rate window in Mbps. The serial rate is twenty times the pixel clock, because each pixel clock carries a 20-bit serial word.

Top module: `serOutSeq`

## Requirements
- R1: After reset, outEnable, termEnable, driveZeroDiff and lockDone are all 0 (OFF state).
- R2: While runReq is 0, all four control outputs stay 0.
- R3: The first clock edge that samples runReq=1 with supplyOk=1 moves the block from OFF to LOCKING. In LOCKING, termEnable=1, driveZeroDiff=1, outEnable=0 and lockDone=0.
- R4: LOCKING lasts exactly LOCK_CYCLES clock cycles (default 17100). On the next edge the block enters ACTIVE: outEnable=1, termEnable=1, driveZeroDiff=0, lockDone=1.
- R5: supplyOk=0 acts as power-down whatever runReq is, including in the cycle where the lock wait would end. The block shows OFF after the next edge.
- R6: A low effective run level in any state returns the block to OFF at the next edge and clears the wait counter. A later start therefore waits the full LOCK_CYCLES again.
- R7: lockDone is 1 only in ACTIVE, and in that state it equals outEnable.
- R8: The rangeSel decode, given in kHz as (min, max), is: 0 gives (2500, 5000), 1 gives (5000, 10000), 2 gives (10000, 20000) and 3 gives (20000, 42000).
- R9: rateMinMbps and rateMaxMbps equal the clock limits times 20 / 1000. This gives 50/100, 100/200, 200/400 and 400/840 for selects 0 to 3.
- R10: outEnable and driveZeroDiff are never 1 together, and outEnable=1 implies termEnable=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runReq | input | 1 | 1 = operate, 0 = power down |
| supplyOk | input | 1 | Input buffer supply present |
| rangeSel | input | 2 | Pixel clock range select |
| outEnable | output | 1 | Serial driver enabled |
| termEnable | output | 1 | Internal termination connected |
| driveZeroDiff | output | 1 | Termination holds the line at zero differential |
| lockDone | output | 1 | Lock wait finished; gates the output shifter |
| clkMinKhz | output | 16 | Lower pixel clock limit of the selected range, kHz |
| clkMaxKhz | output | 16 | Upper pixel clock limit of the selected range, kHz |
| rateMinMbps | output | 10 | Lower serial rate of the selected range, Mbps |
| rateMaxMbps | output | 10 | Upper serial rate of the selected range, Mbps |

## Verification
Two events can fall in the same cycle: the end of the lock wait and a loss of the input supply. The bench lets the counter run exactly LOCK_CYCLES cycles, which puts it on its terminal count. It then drops supplyOk just before the edge that would enter ACTIVE. The block passes if it shows OFF with lockDone=0 after that edge, and if the next start waits the full interval again rather than resuming the old count.

// File: rtl/serOutSeqPkg.sv
package serOutSeqPkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_LOCKING = 2'd1,
    ST_ACTIVE  = 2'd2
  } seqStateT;

  // strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } seqStrobeT;

  localparam int KHZ_W  = 16;
  localparam int RATE_W = 10;
  // serial word bits per pixel clock, and kHz per Mbps
  localparam int WORD_BITS = 20;
  localparam int KHZ_PER_MHZ = 1000;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import serOutSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runReq,
  input  logic      supplyOk,
  input  logic      termHit,
  output seqStrobeT strobe,
  output logic      outEnable,
  output logic      termEnable,
  output logic      driveZeroDiff,
  output logic      lockDone
);

  seqStateT state, stateNext;
  logic effRun;

  // a missing input supply overrides the run request
  assign effRun = runReq && supplyOk;

  always_comb begin
    stateNext = state;
    if (!effRun) begin
      stateNext = ST_OFF;
    end else begin
      case (state)
        ST_OFF:     stateNext = ST_LOCKING;
        ST_LOCKING: stateNext = termHit ? ST_ACTIVE : ST_LOCKING;
        ST_ACTIVE:  stateNext = ST_ACTIVE;
        default:    stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.cntClear = !effRun || (state != ST_LOCKING);
    strobe.cntRun   = effRun && (state == ST_LOCKING) && !termHit;
  end

  assign termEnable    = (state != ST_OFF);
  assign driveZeroDiff = (state == ST_LOCKING);
  assign outEnable     = (state == ST_ACTIVE);
  assign lockDone      = (state == ST_ACTIVE);

  // R5 R6
  power_drop_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(runReq && supplyOk) |=> (!termEnable && !outEnable && !lockDone));

  // R3
  lock_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(termEnable) |-> (driveZeroDiff && !outEnable));

  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockDone) |-> ($past(termHit) && $past(driveZeroDiff)));

  // R10
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |-> (termEnable && !driveZeroDiff));

endmodule

// File: rtl/lockRangeDp.sv
module lockRangeDp
  import serOutSeqPkg::*;
#(
  parameter int LOCK_CYCLES = 17100
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [1:0]        rangeSel,
  output logic              termHit,
  output logic [KHZ_W-1:0]  clkMinKhz,
  output logic [KHZ_W-1:0]  clkMaxKhz,
  output logic [RATE_W-1:0] rateMinMbps,
  output logic [RATE_W-1:0] rateMaxMbps
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] lockCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockCnt <= '0;
    else if (strobe.cntClear) lockCnt <= '0;
    else if (strobe.cntRun)   lockCnt <= lockCnt + 1'b1;
  end

  assign termHit = (lockCnt == CNT_LAST);

  // clock window per select, in kHz
  always_comb begin
    case (rangeSel)
      2'd0:    begin clkMinKhz = KHZ_W'(2500);  clkMaxKhz = KHZ_W'(5000);  end
      2'd1:    begin clkMinKhz = KHZ_W'(5000);  clkMaxKhz = KHZ_W'(10000); end
      2'd2:    begin clkMinKhz = KHZ_W'(10000); clkMaxKhz = KHZ_W'(20000); end
      default: begin clkMinKhz = KHZ_W'(20000); clkMaxKhz = KHZ_W'(42000); end
    endcase
  end

  // serial rate window per select, in Mbps, kept as its own decode
  always_comb begin
    case (rangeSel)
      2'd0:    begin rateMinMbps = RATE_W'(50);  rateMaxMbps = RATE_W'(100); end
      2'd1:    begin rateMinMbps = RATE_W'(100); rateMaxMbps = RATE_W'(200); end
      2'd2:    begin rateMinMbps = RATE_W'(200); rateMaxMbps = RATE_W'(400); end
      default: begin rateMinMbps = RATE_W'(400); rateMaxMbps = RATE_W'(840); end
    endcase
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= CNT_LAST);

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.cntClear) |-> (lockCnt == '0));

  // R9
  rate_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rateMinMbps) * KHZ_PER_MHZ == int'(clkMinKhz) * WORD_BITS) &&
    (int'(rateMaxMbps) * KHZ_PER_MHZ == int'(clkMaxKhz) * WORD_BITS));

endmodule

// File: rtl/serOutSeq.sv
module serOutSeq
  import serOutSeqPkg::*;
#(
  parameter int LOCK_CYCLES = 17100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runReq,
  input  logic              supplyOk,
  input  logic [1:0]        rangeSel,
  output logic              outEnable,
  output logic              termEnable,
  output logic              driveZeroDiff,
  output logic              lockDone,
  output logic [KHZ_W-1:0]  clkMinKhz,
  output logic [KHZ_W-1:0]  clkMaxKhz,
  output logic [RATE_W-1:0] rateMinMbps,
  output logic [RATE_W-1:0] rateMaxMbps
);

  seqStrobeT strobe;
  logic termHit;

  seqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .supplyOk(supplyOk),
    .termHit(termHit), .strobe(strobe), .outEnable(outEnable),
    .termEnable(termEnable), .driveZeroDiff(driveZeroDiff), .lockDone(lockDone)
  );

  lockRangeDp #(.LOCK_CYCLES(LOCK_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rangeSel(rangeSel),
    .termHit(termHit), .clkMinKhz(clkMinKhz), .clkMaxKhz(clkMaxKhz),
    .rateMinMbps(rateMinMbps), .rateMaxMbps(rateMaxMbps)
  );

  // R7
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockDone == outEnable);

endmodule

// File: tb/serOutSeq_tb.sv
module serOutSeq_tb;

  localparam int N = 17100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runReq = 1'b0;
  logic supplyOk = 1'b1;
  logic [1:0] rangeSel = 2'd0;
  logic outEnable, termEnable, driveZeroDiff, lockDone;
  logic [15:0] clkMinKhz, clkMaxKhz;
  logic [9:0] rateMinMbps, rateMaxMbps;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  serOutSeq u_dut (
    .clk(clk), .rstN(rstN), .runReq(runReq), .supplyOk(supplyOk),
    .rangeSel(rangeSel), .outEnable(outEnable), .termEnable(termEnable),
    .driveZeroDiff(driveZeroDiff), .lockDone(lockDone),
    .clkMinKhz(clkMinKhz), .clkMaxKhz(clkMaxKhz),
    .rateMinMbps(rateMinMbps), .rateMaxMbps(rateMaxMbps)
  );

  // {sel, clkMin, clkMax, rateMin, rateMax}
  localparam logic [53:0] RANGE_VEC [4] = '{
    {2'd0, 16'd2500,  16'd5000,  10'd50,  10'd100},
    {2'd1, 16'd5000,  16'd10000, 10'd100, 10'd200},
    {2'd2, 16'd10000, 16'd20000, 10'd200, 10'd400},
    {2'd3, 16'd20000, 16'd42000, 10'd400, 10'd840}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // control outputs packed as {outEnable, termEnable, driveZeroDiff, lockDone}
  function automatic int ctl();
    return int'({outEnable, termEnable, driveZeroDiff, lockDone});
  endfunction

  localparam int OFF_C  = 4'b0000;
  localparam int LOCK_C = 4'b0110;
  localparam int ACT_C  = 4'b1101;

  task automatic expectCtl(input int exp, input string tag);
    check(ctl() == exp, tag, ctl(), exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    expectCtl(OFF_C, "R1 in reset");
    rstN = 1'b1;
    tick(1);
    expectCtl(OFF_C, "R1 after reset");

    tick(5);
    expectCtl(OFF_C, "R2 runReq low");

    // R8 R9 range table walk
    for (int i = 0; i < 4; i++) begin
      rangeSel = RANGE_VEC[i][53:52];
      tick(1);
      check(clkMinKhz == RANGE_VEC[i][51:36], "R8 clkMin", clkMinKhz, RANGE_VEC[i][51:36]);
      check(clkMaxKhz == RANGE_VEC[i][35:20], "R8 clkMax", clkMaxKhz, RANGE_VEC[i][35:20]);
      check(rateMinMbps == RANGE_VEC[i][19:10], "R9 rateMin", rateMinMbps, RANGE_VEC[i][19:10]);
      check(rateMaxMbps == RANGE_VEC[i][9:0], "R9 rateMax", rateMaxMbps, RANGE_VEC[i][9:0]);
    end

    // full lock sequence
    runReq = 1'b1;
    tick(1);
    expectCtl(LOCK_C, "R3 locking entry");
    tick(N - 1);
    expectCtl(LOCK_C, "R4 last locking cycle");
    tick(1);
    expectCtl(ACT_C, "R4 active after wait");
    check(lockDone == outEnable, "R7 lockDone tracks outEnable", lockDone, outEnable);
    check(!(outEnable && driveZeroDiff), "R10 exclusive", ctl(), ACT_C);
    rangeSel = 2'd1;
    tick(3);
    expectCtl(ACT_C, "R4 stays active");

    // drop in ACTIVE
    runReq = 1'b0;
    tick(1);
    expectCtl(OFF_C, "R6 drop from active");

    // partial lock, drop, restart must wait the full interval
    runReq = 1'b1;
    tick(100);
    expectCtl(LOCK_C, "R3 partial locking");
    runReq = 1'b0;
    tick(1);
    expectCtl(OFF_C, "R6 drop from locking");
    check(lockDone == 1'b0, "R7 no lock in OFF", lockDone, 0);
    runReq = 1'b1;
    tick(N);
    expectCtl(LOCK_C, "R6 counter cleared, still locking");
    tick(1);
    expectCtl(ACT_C, "R6 active after full wait");

    // supply loss while active
    supplyOk = 1'b0;
    tick(1);
    expectCtl(OFF_C, "R5 supply loss in active");
    tick(20);
    expectCtl(OFF_C, "R5 supply absent holds off");
    supplyOk = 1'b1;
    tick(1);
    expectCtl(LOCK_C, "R5 supply back starts lock");

    // supply loss on the terminal-count edge
    tick(N - 1);
    expectCtl(LOCK_C, "R5 at terminal count");
    supplyOk = 1'b0;
    tick(1);
    expectCtl(OFF_C, "R5 loss beats lock completion");
    supplyOk = 1'b1;
    tick(N);
    expectCtl(LOCK_C, "R6 full wait after collision");
    tick(1);
    expectCtl(ACT_C, "R4 active after collision restart");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule